// File: doc/BRIEF.md
# Opportunistic-Fetch Instruction Issue Front End

This block is the issue front end of one hardware thread. It keeps a small window of instruction bits and shares one 32-bit memory port between instruction fetch and the data accesses of the instructions it issues. Every clock cycle it puts one slot on its issue output. That slot holds a 16-bit or 32-bit instruction, or a fetch-only no-op when the window has no complete instruction. No cycle is set aside for fetching. The port fetches the next word only when the instruction issued in that cycle does not need it for a load or store, and only when the window can take the whole word.

A taken jump arrives on the redirect input. It empties the window and drops any word still in flight. The slot after the redirect carries no instruction. It fetches the word-aligned word that holds the target. If the target sits at an odd halfword, the lower halfword of that word is dropped. Long instructions and loads/stores that come in a run drain the window, and the stream then shows fetch no-ops. Two counters, one for issued instructions and one for fetch no-ops, make this visible at the ports.

The memory port returns the word for a fetch requested in cycle c so that it is stable at the clock edge that ends cycle c.

Top module: `ifb_frontend`

## Requirements
- R1: While `rst` is high, `issue_valid`, `issue_fnop`, `mem_fetch_req` and both counters are 0. In the first cycle after reset the block issues a fetch no-op and fetches from `RESET_ADDR`.
- R2: An instruction's first halfword decides its kind. Bit 15 set means a 32-bit instruction and bit 14 set means a load/store. A long instruction is issued as {second halfword, first halfword}. A short one is issued with the upper 16 bits zero, and `issue_long`/`issue_mem` carry the two bits.
- R3: Instructions are issued in ascending halfword order from the redirect target, with none lost or repeated.
- R4: A cycle that issues a load/store instruction makes no fetch.
- R5: A fetch is made only if the window, counting any in-flight word, still has at least 32 free bits after the cycle's issue. A run of short non-memory instructions from an aligned target therefore fetches in cycles 0..5 after the redirect as 1,1,1,0,1,0.
- R6: When the window holds no complete instruction, a fetch no-op is issued, and that slot always fetches.
- R7: The slot after a sampled redirect issues nothing and fetches the word holding the target (address with bits [1:0] cleared). The first target instruction issues in the next cycle. Buffered and in-flight bits from before the redirect are never issued.
- R8: For an odd-halfword target the leading halfword of the first word is dropped. A run of long non-memory instructions from such a target shows exactly one fetch no-op before its fifth instruction.
- R9: Successive fetches with no redirect between them use addresses 4 bytes apart.
- R10: `perf_issued` and `perf_fnops` count issued instructions and fetch no-ops since reset.
- R11: Runs of memory instructions show bubbles. Eight short loads/stores from an aligned target carry 3 fetch no-ops, and six long loads/stores carry 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| redirect_valid | input | 1 | Taken jump, sampled at the clock edge |
| redirect_addr | input | AW | Byte address of the jump target |
| mem_fetch_req | output | 1 | Memory port is used for an instruction fetch this cycle |
| mem_fetch_addr | output | AW | Word-aligned fetch address |
| mem_rdata | input | 32 | Fetched word, stable at the edge ending the request cycle |
| issue_valid | output | 1 | Issue slot is occupied (instruction or fetch no-op) |
| issue_fnop | output | 1 | Slot is a fetch-only no-op |
| issue_long | output | 1 | Issued instruction is 32 bits |
| issue_mem | output | 1 | Issued instruction uses the memory port for data |
| issue_word | output | 32 | Issued instruction bits |
| perf_issued | output | CW | Issued instruction count |
| perf_fnops | output | CW | Fetch no-op count |

## Verification
A redirect sampled at edge k yields the target fetch and an empty slot in cycle k, and the first target instruction in cycle k+1. The bench therefore clears its per-run tallies in cycle k and records the fetch-request pattern for cycles k through k+7. Issue outputs and counters are registered at the same edge, so every slot, along with the counter values that include it, is sampled at the falling edge of that same cycle. The bench drives fetched words at the falling edge of the request cycle, so each word arrives at the edge that ends it.

// File: rtl/ifb_pkg.sv
package ifb_pkg;
  localparam int HW       = 16;
  localparam int WORD     = 32;
  localparam int LONG_BIT = 15;
  localparam int MEM_BIT  = 14;
endpackage

// File: rtl/ifb_window.sv
// Combines held halfwords with the word arriving at this edge.
module ifb_window
  import ifb_pkg::*;
#(
  parameter int NHW  = 4,
  parameter int CNTW = $clog2(NHW + 1)
) (
  input  logic [NHW-1:0][HW-1:0] held_hw,
  input  logic [CNTW-1:0]        held_cnt,
  input  logic                   arr_valid,
  input  logic                   arr_skip,
  input  logic [WORD-1:0]        arr_word,
  output logic [NHW-1:0][HW-1:0] win_hw,
  output logic [CNTW-1:0]        win_cnt
);
  logic [HW-1:0] first_arr;
  logic [HW-1:0] second_arr;
  logic          second_ok;

  assign first_arr  = arr_skip ? arr_word[WORD-1:HW] : arr_word[HW-1:0];
  assign second_arr = arr_word[WORD-1:HW];
  assign second_ok  = arr_valid && !arr_skip;
  assign win_cnt    = held_cnt + (arr_valid ? (arr_skip ? CNTW'(1) : CNTW'(2)) : CNTW'(0));

  for (genvar i = 0; i < NHW; i++) begin : g_slot
    localparam logic [CNTW-1:0] SLOT = CNTW'(i);
    assign win_hw[i] = (SLOT < held_cnt)                 ? held_hw[i] :
                       (SLOT == held_cnt)                ? (arr_valid ? first_arr : '0) :
                       (SLOT == held_cnt + CNTW'(1))     ? (second_ok ? second_arr : '0) :
                                                           '0;
  end
endmodule

// File: rtl/ifb_pick.sv
// Picks the head instruction, shifts the window, decides on a fetch.
module ifb_pick
  import ifb_pkg::*;
#(
  parameter int NHW  = 4,
  parameter int CNTW = $clog2(NHW + 1)
) (
  input  logic [NHW-1:0][HW-1:0] win_hw,
  input  logic [CNTW-1:0]        win_cnt,
  output logic                   complete,
  output logic                   head_long,
  output logic                   head_mem,
  output logic [WORD-1:0]        head_word,
  output logic [NHW-1:0][HW-1:0] rest_hw,
  output logic [CNTW-1:0]        rest_cnt,
  output logic                   fetch_ok
);
  logic [CNTW-1:0] used;

  assign head_long = win_hw[0][LONG_BIT];
  assign head_mem  = win_hw[0][MEM_BIT];
  assign complete  = (win_cnt >= CNTW'(1)) && (!head_long || win_cnt >= CNTW'(2));
  assign used      = complete ? (head_long ? CNTW'(2) : CNTW'(1)) : CNTW'(0);
  assign head_word = head_long ? {win_hw[1], win_hw[0]} : {{HW{1'b0}}, win_hw[0]};
  assign rest_cnt  = win_cnt - used;
  assign fetch_ok  = !(complete && head_mem) && (rest_cnt <= CNTW'(NHW - 2));

  for (genvar i = 0; i < NHW; i++) begin : g_shift
    if (i + 2 < NHW) begin : g_two
      assign rest_hw[i] = (used == CNTW'(2)) ? win_hw[i+2] :
                          (used == CNTW'(1)) ? win_hw[i+1] : win_hw[i];
    end else if (i + 1 < NHW) begin : g_one
      assign rest_hw[i] = (used == CNTW'(2)) ? '0 :
                          (used == CNTW'(1)) ? win_hw[i+1] : win_hw[i];
    end else begin : g_top
      assign rest_hw[i] = (used == CNTW'(0)) ? win_hw[i] : '0;
    end
  end
endmodule

// File: rtl/ifb_perf.sv
module ifb_perf #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bump_issue,
  input  logic          bump_fnop,
  output logic [CW-1:0] n_issue,
  output logic [CW-1:0] n_fnop
);
  always_ff @(posedge clk) begin
    if (rst) begin
      n_issue <= '0;
      n_fnop  <= '0;
    end else begin
      if (bump_issue) n_issue <= n_issue + CW'(1);
      if (bump_fnop)  n_fnop  <= n_fnop + CW'(1);
    end
  end
endmodule

// File: rtl/ifb_frontend.sv
module ifb_frontend
  import ifb_pkg::*;
#(
  parameter int              AW         = 16,
  parameter int              BUF_BITS   = 64,
  parameter int              CW         = 16,
  parameter logic [AW-1:0]   RESET_ADDR = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            redirect_valid,
  input  logic [AW-1:0]   redirect_addr,
  output logic            mem_fetch_req,
  output logic [AW-1:0]   mem_fetch_addr,
  input  logic [WORD-1:0] mem_rdata,
  output logic            issue_valid,
  output logic            issue_fnop,
  output logic            issue_long,
  output logic            issue_mem,
  output logic [WORD-1:0] issue_word,
  output logic [CW-1:0]   perf_issued,
  output logic [CW-1:0]   perf_fnops
);
  localparam int NHW  = BUF_BITS / HW;
  localparam int CNTW = $clog2(NHW + 1);

  logic [NHW-1:0][HW-1:0] held_hw, win_hw, rest_hw;
  logic [CNTW-1:0]        held_cnt, win_cnt, rest_cnt;
  logic                   skip_q;
  logic [AW-1:0]          next_pc;
  logic                   complete, head_long, head_mem, fetch_ok;
  logic [WORD-1:0]        head_word;
  logic [AW-1:0]          target_word;
  logic                   unused_addr_bit0;

  assign target_word      = {redirect_addr[AW-1:2], 2'b00};
  assign unused_addr_bit0 = redirect_addr[0];

  ifb_window #(.NHW(NHW), .CNTW(CNTW)) u_window (
    .held_hw  (held_hw),
    .held_cnt (held_cnt),
    .arr_valid(mem_fetch_req),
    .arr_skip (skip_q),
    .arr_word (mem_rdata),
    .win_hw   (win_hw),
    .win_cnt  (win_cnt)
  );

  ifb_pick #(.NHW(NHW), .CNTW(CNTW)) u_pick (
    .win_hw   (win_hw),
    .win_cnt  (win_cnt),
    .complete (complete),
    .head_long(head_long),
    .head_mem (head_mem),
    .head_word(head_word),
    .rest_hw  (rest_hw),
    .rest_cnt (rest_cnt),
    .fetch_ok (fetch_ok)
  );

  ifb_perf #(.CW(CW)) u_perf (
    .clk       (clk),
    .rst       (rst),
    .bump_issue(!redirect_valid && complete),
    .bump_fnop (!redirect_valid && !complete),
    .n_issue   (perf_issued),
    .n_fnop    (perf_fnops)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      held_hw        <= '0;
      held_cnt       <= '0;
      skip_q         <= 1'b0;
      next_pc        <= RESET_ADDR;
      mem_fetch_req  <= 1'b0;
      mem_fetch_addr <= '0;
      issue_valid    <= 1'b0;
      issue_fnop     <= 1'b0;
      issue_long     <= 1'b0;
      issue_mem      <= 1'b0;
      issue_word     <= '0;
    end else if (redirect_valid) begin
      held_cnt       <= '0;
      skip_q         <= redirect_addr[1];
      mem_fetch_req  <= 1'b1;
      mem_fetch_addr <= target_word;
      next_pc        <= target_word + AW'(4);
      issue_valid    <= 1'b0;
      issue_fnop     <= 1'b0;
      issue_long     <= 1'b0;
      issue_mem      <= 1'b0;
      issue_word     <= '0;
    end else begin
      held_hw       <= rest_hw;
      held_cnt      <= rest_cnt;
      skip_q        <= 1'b0;
      mem_fetch_req <= fetch_ok;
      if (fetch_ok) begin
        mem_fetch_addr <= next_pc;
        next_pc        <= next_pc + AW'(4);
      end
      issue_valid <= 1'b1;
      issue_fnop  <= !complete;
      issue_long  <= complete && head_long;
      issue_mem   <= complete && head_mem;
      issue_word  <= complete ? head_word : '0;
    end
  end
endmodule

// File: rtl/ifb_frontend_chk.sv
module ifb_frontend_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          redirect_valid,
  input logic [AW-1:0] redirect_addr,
  input logic          mem_fetch_req,
  input logic [AW-1:0] mem_fetch_addr,
  input logic          issue_valid,
  input logic          issue_fnop,
  input logic          issue_long,
  input logic          issue_mem,
  input logic [31:0]   issue_word,
  input logic [CW-1:0] perf_issued,
  input logic [CW-1:0] perf_fnops
);
  a_r4_mem_blocks_fetch: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && !issue_fnop && issue_mem) |-> !mem_fetch_req);

  a_r6_fnop_fetches: assert property (@(posedge clk) disable iff (rst)
    issue_fnop |-> (issue_valid && mem_fetch_req));

  a_r7_redirect_slot: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |=> (mem_fetch_req && !issue_valid &&
                        mem_fetch_addr == {$past(redirect_addr[AW-1:2]), 2'b00}));

  a_r9_sequential_fetch: assert property (@(posedge clk) disable iff (rst)
    ($past(mem_fetch_req) && mem_fetch_req && !$past(redirect_valid)) |->
      mem_fetch_addr == $past(mem_fetch_addr) + AW'(4));

  a_r2_short_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && !issue_long) |-> issue_word[31:16] == 16'h0);

  a_r2_kind_bits: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && !issue_fnop) |-> (issue_word[15] == issue_long && issue_word[14] == issue_mem));

  a_r10_issue_count: assert property (@(posedge clk) disable iff (rst)
    perf_issued == $past(perf_issued) + CW'(issue_valid && !issue_fnop));

  a_r10_fnop_count: assert property (@(posedge clk) disable iff (rst)
    perf_fnops == $past(perf_fnops) + CW'(issue_fnop));

  always @(posedge clk) begin
    if (rst) begin
      a_r1_reset_quiet: assert (!issue_valid && !mem_fetch_req && perf_issued == '0);
    end
  end
endmodule

bind ifb_frontend ifb_frontend_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
  .mem_fetch_req(mem_fetch_req), .mem_fetch_addr(mem_fetch_addr),
  .issue_valid(issue_valid), .issue_fnop(issue_fnop), .issue_long(issue_long),
  .issue_mem(issue_mem), .issue_word(issue_word),
  .perf_issued(perf_issued), .perf_fnops(perf_fnops)
);

// File: tb/ifb_frontend_test.sv
`timescale 1ns/1ps
module ifb_frontend_test;
  localparam int AW = 16;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          redirect_valid = 1'b0;
  logic [AW-1:0] redirect_addr = '0;
  logic          mem_fetch_req;
  logic [AW-1:0] mem_fetch_addr;
  logic [31:0]   mem_rdata = '0;
  logic          issue_valid, issue_fnop, issue_long, issue_mem;
  logic [31:0]   issue_word;
  logic [CW-1:0] perf_issued, perf_fnops;

  always #2 clk = ~clk;

  ifb_frontend #(.AW(AW), .CW(CW), .RESET_ADDR('0)) uut (
    .clk(clk), .rst(rst), .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
    .mem_fetch_req(mem_fetch_req), .mem_fetch_addr(mem_fetch_addr), .mem_rdata(mem_rdata),
    .issue_valid(issue_valid), .issue_fnop(issue_fnop), .issue_long(issue_long),
    .issue_mem(issue_mem), .issue_word(issue_word),
    .perf_issued(perf_issued), .perf_fnops(perf_fnops)
  );

  logic [15:0] mem_h [0:255];
  int checks = 0, failures = 0;
  bit done = 0;
  int tot_instr = 0, tot_fnop = 0;
  int exp_p = 0, scen_n = 0, seen_i = 0, seen_f = 0, fn_at_n = 0, mism = 0;
  bit [7:0] fhist;
  bit slot0_valid;
  int first_i, first_f;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: memory responses and issue stream, sampled at the falling edge.
  always @(negedge clk) begin
    if (!rst) begin
      int a;
      a = int'(mem_fetch_addr) >> 1;
      mem_rdata = mem_fetch_req ? {mem_h[(a + 1) & 255], mem_h[a & 255]} : 32'h0;
      if (issue_valid && issue_fnop) begin
        tot_fnop++;
        if (seen_i < scen_n) seen_f++;
      end else if (issue_valid) begin
        tot_instr++;
        if (seen_i < scen_n) begin
          logic [15:0] h0;
          logic [31:0] ew;
          bit lg;
          h0 = mem_h[exp_p & 255];
          lg = h0[15];
          ew = lg ? {mem_h[(exp_p + 1) & 255], h0} : {16'h0, h0};
          if (ew !== issue_word || issue_long !== lg || issue_mem !== h0[14]) mism++;
          exp_p += lg ? 2 : 1;
          seen_i++;
          if (seen_i == scen_n) fn_at_n = seen_f;
        end
      end
    end
  end

  // kind: 0 short plain, 1 long plain, 2 short load/store, 3 long load/store, 4 mixed
  task automatic fill(input int base, input int n, input int kind);
    int p = base;
    for (int i = 0; i < n + 4; i++) begin
      int k = (kind == 4) ? (i % 4) : kind;
      bit lg = (k == 1 || k == 3);
      bit mm = (k == 2 || k == 3);
      mem_h[p & 255] = {lg, mm, 14'(i * 5 + base)};
      p++;
      if (lg) begin
        mem_h[p & 255] = 16'(16'hA000 + i + base);
        p++;
      end
    end
  endtask

  task automatic run(input int base, input int n, input string req);
    @(negedge clk);
    redirect_valid = 1'b1;
    redirect_addr  = AW'(base * 2);
    @(negedge clk); #1;
    redirect_valid = 1'b0;
    exp_p = base; scen_n = n; seen_i = 0; seen_f = 0; fn_at_n = -1; mism = 0;
    fhist = '0;
    fhist[0] = mem_fetch_req;
    slot0_valid = issue_valid;
    check(mem_fetch_addr == AW'((base * 2) & ~3), "R7 redirect fetch address",
          mem_fetch_addr, (base * 2) & ~3);
    for (int c = 1; c < 400; c++) begin
      @(negedge clk); #1;
      if (c < 8) fhist[c] = mem_fetch_req;
      if (c == 1) begin first_i = seen_i; first_f = seen_f; end
      if (seen_i >= n && c >= 8) break;
    end
    check(seen_i == n, {req, " instruction count"}, seen_i, n);
    check(mism == 0, "R3 R2 issue order and fields", mism, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem_h[i] = 16'h0;
    repeat (3) @(negedge clk);
    // R1: quiet during reset
    check(issue_valid == 1'b0, "R1 issue_valid in reset", issue_valid, 0);
    check(mem_fetch_req == 1'b0, "R1 fetch in reset", mem_fetch_req, 0);
    check(perf_issued == 0 && perf_fnops == 0, "R1 counters in reset", perf_issued + perf_fnops, 0);
    rst = 1'b0;
    @(negedge clk); #1;
    check(issue_fnop == 1'b1, "R1 first slot fetch no-op", issue_fnop, 1);
    check(mem_fetch_req && mem_fetch_addr == 0, "R1 first fetch at reset address", mem_fetch_addr, 0);

    // R5 R7: short plain instructions from an aligned target
    fill(32, 10, 0);
    run(32, 10, "R5");
    check(slot0_valid == 1'b0, "R7 redirect slot empty", slot0_valid, 0);
    check(first_i == 1, "R7 first instruction one cycle after redirect slot", first_i, 1);
    check(fhist[5:0] == 6'b010111, "R5 fetch pattern", fhist[5:0], 6'b010111);
    check(fn_at_n == 0, "R5 no fetch no-ops for short plain run", fn_at_n, 0);

    // Long plain, aligned
    fill(64, 8, 1);
    run(64, 8, "R3");
    check(fn_at_n == 0, "R3 no fetch no-ops for long plain run", fn_at_n, 0);

    // R8: long plain, odd-halfword target
    fill(97, 5, 1);
    run(97, 5, "R8");
    check(first_f == 1 && first_i == 0, "R8 leading fetch no-op", first_f, 1);
    check(fn_at_n == 1, "R8 fetch no-op count", fn_at_n, 1);

    // Short plain, odd-halfword target
    fill(129, 9, 0);
    run(129, 9, "R8");
    check(fn_at_n == 0, "R8 short odd target no-ops", fn_at_n, 0);

    // R11 R4 R6: short load/store run
    fill(160, 8, 2);
    run(160, 8, "R11");
    check(fn_at_n == 3, "R11 short load/store bubbles", fn_at_n, 3);
    check(fhist[2:0] == 3'b001, "R4 no fetch while issuing loads/stores", fhist[2:0], 3'b001);
    check(fhist[3] == 1'b1, "R6 fetch no-op carries fetch", fhist[3], 1);

    // R11: long load/store run
    fill(192, 6, 3);
    run(192, 6, "R11");
    check(fn_at_n == 5, "R11 long load/store bubbles", fn_at_n, 5);

    // Mixed kinds, order only
    fill(224, 12, 4);
    run(224, 12, "R3");

    // R10: counters match the observed stream
    @(negedge clk); #1;
    check(int'(perf_issued) == tot_instr, "R10 issued counter", perf_issued, tot_instr);
    check(int'(perf_fnops) == tot_fnop, "R10 fetch no-op counter", perf_fnops, tot_fnop);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule